// File: doc/BRIEF.md
# Sequenced Palette Color Map

This block holds a 256-entry indexed color table whose entries are loaded from a host through two registers in a small write window. One register selects the entry to load. The other register takes color bytes. Bytes written to the color register fill the red, green and blue components of the selected entry in that order. After blue, the block moves on to the next entry by itself, so software can stream a whole table after one index write.

The color register accepts either a single byte or a full 32-bit word. A word is split into four component bytes, most significant byte first. These bytes are applied over four internal cycles, and the bus ready signal stays low until they have all been stored. Both registers read back as zero.

On the display side, a combinational lookup port turns an 8-bit pixel index into a packed 24-bit RGB value. A redraw flag tells downstream display logic that the table has changed. The display side clears the flag with a one-cycle acknowledge pulse.

Top module: `seq_palette`

## Requirements
- R1: A write accepted at byte offset 0x0 (the index register) loads `wdata_i[7:0]` as the current index and returns the component phase to red.
- R2: Each component byte written to the color register at offset 0x4 is stored into the current entry. The bytes go to red, then green, then blue, and the phase advances after every byte.
- R3: Storing a blue component increments the current index modulo 256 (so 0xFF wraps to 0x00) and returns the phase to red.
- R4: A write with `size_i`=0 supplies one component byte from `wdata_i[7:0]` and completes at its accepting edge. A write with `size_i`=1 supplies four component bytes, taken in the order `wdata_i[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. These are stored on the four edges after acceptance, and `ready_o` is low for exactly those four cycles and high at all other times.
- R5: Reads (`we_i`=0) of either register return `rdata_o` = 0.
- R6: Every accepted write to the color register sets `redraw_o` on the next edge. An `redraw_ack_i` pulse clears it, but a color-register write in the same cycle wins over the acknowledge.
- R7: Reset clears all 768 component bytes to zero, sets the index to 0 and the phase to red, and sets `redraw_o` to 1.
- R8: `pix_rgb_o` equals {red, green, blue} of entry `pix_idx_i`, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R9: Writes to any other offset change no entry, no index and no phase, and they leave `ready_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset in the register window |
| size_i | input | 1 | 0 = byte write, 1 = 32-bit write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, always zero |
| ready_o | output | 1 | Request accepted when high |
| pix_idx_i | input | 8 | Pixel index for lookup |
| pix_rgb_o | output | 24 | Packed RGB of the looked-up entry |
| redraw_o | output | 1 | Full-redraw request |
| redraw_ack_i | input | 1 | One-cycle clear of the redraw request |

## Verification
The assertions check the following on every cycle:
- how the index and phase move for each stored component byte, including the blue-to-next-entry step;
- that an index write takes effect;
- that `ready_o` drops after a word write and never stays low longer than four cycles;
- how the redraw flag is set and acknowledged.

Some behaviour only the bench's scenarios can show:
- that the bytes of a word land in the right entries, in most-significant-first order, including across the wrap from entry 0xFF to entry 0x00;
- that reads return zero;
- that writes to other offsets leave the table untouched;
- that a reset in the middle of loading an entry clears the table and the sequence.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {PH_R = 2'd0, PH_G = 2'd1, PH_B = 2'd2} phase_e;
endpackage

// File: rtl/pal_wr_seq.sv
module pal_wr_seq #(
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 5,
  parameter int COMP_W   = 8,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic              ready_o,
  output logic              idx_wr_o,
  output logic              data_wr_o,
  output logic              comp_we_o,
  output logic [COMP_W-1:0] comp_o
);
  localparam int NBYTES = BUS_W / COMP_W;
  localparam int CNT_W  = $clog2(NBYTES) > 0 ? $clog2(NBYTES) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] left_q;
  logic [BUS_W-1:0] sh_q;
  logic             acc, data_hit, byte_wr, word_wr;

  assign ready_o   = ~busy_q;
  assign acc       = req_i & we_i & ready_o;
  assign data_hit  = addr_i == ADDR_W'(DATA_OFS);
  assign idx_wr_o  = acc & (addr_i == ADDR_W'(IDX_OFS));
  assign data_wr_o = acc & data_hit;
  assign byte_wr   = data_wr_o & ~size_i;
  assign word_wr   = data_wr_o & size_i;

  // serialized word bytes take the component path while busy
  assign comp_we_o = byte_wr | busy_q;
  assign comp_o    = busy_q ? sh_q[BUS_W-1 -: COMP_W] : wdata_i[COMP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      left_q <= '0;
      sh_q   <= '0;
    end else if (word_wr) begin
      busy_q <= 1'b1;
      left_q <= CNT_W'(NBYTES - 1);
      sh_q   <= wdata_i;
    end else if (busy_q) begin
      sh_q <= sh_q << COMP_W;
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/pal_ptr.sv
module pal_ptr
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_wr_i,
  input  logic [IDX_W-1:0] idx_val_i,
  input  logic             comp_we_i,
  output logic [IDX_W-1:0] idx_o,
  output phase_e           phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      phase_o <= PH_R;
    end else if (idx_wr_i) begin
      idx_o   <= idx_val_i;
      phase_o <= PH_R;
    end else if (comp_we_i) begin
      unique case (phase_o)
        PH_R:    phase_o <= PH_G;
        PH_G:    phase_o <= PH_B;
        default: begin
          phase_o <= PH_R;
          idx_o   <= idx_o + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  phase_e            phase_i,
  input  logic [COMP_W-1:0] comp_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [3*COMP_W-1:0] rgb_o
);
  localparam int NENT = 1 << IDX_W;

  logic [COMP_W-1:0] red_q [NENT];
  logic [COMP_W-1:0] grn_q [NENT];
  logic [COMP_W-1:0] blu_q [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic hit;
    assign hit = we_i && (idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        red_q[e] <= '0;
        grn_q[e] <= '0;
        blu_q[e] <= '0;
      end else if (hit) begin
        if (phase_i == PH_R) red_q[e] <= comp_i;
        if (phase_i == PH_G) grn_q[e] <= comp_i;
        if (phase_i == PH_B) blu_q[e] <= comp_i;
      end
    end
  end

  assign rgb_o = {red_q[rd_idx_i], grn_q[rd_idx_i], blu_q[rd_idx_i]};
endmodule

// File: rtl/seq_palette.sv
module seq_palette
  import pal_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 8,
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 5,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                size_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  output logic                ready_o,
  input  logic [IDX_W-1:0]    pix_idx_i,
  output logic [3*COMP_W-1:0] pix_rgb_o,
  output logic                redraw_o,
  input  logic                redraw_ack_i
);
  logic              idx_wr, data_wr, comp_we;
  logic [COMP_W-1:0] comp;
  logic [IDX_W-1:0]  idx_q;
  phase_e            phase_q;

  // both registers are write-only
  assign rdata_o = '0;

  pal_wr_seq #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .COMP_W(COMP_W),
    .IDX_OFS(IDX_OFS), .DATA_OFS(DATA_OFS)
  ) i_wr_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .ready_o,
    .idx_wr_o  (idx_wr),
    .data_wr_o (data_wr),
    .comp_we_o (comp_we),
    .comp_o    (comp)
  );

  pal_ptr #(.IDX_W(IDX_W)) i_ptr (
    .clk_i, .rst_ni,
    .idx_wr_i  (idx_wr),
    .idx_val_i (wdata_i[IDX_W-1:0]),
    .comp_we_i (comp_we),
    .idx_o     (idx_q),
    .phase_o   (phase_q)
  );

  pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) i_store (
    .clk_i, .rst_ni,
    .we_i     (comp_we),
    .idx_i    (idx_q),
    .phase_i  (phase_q),
    .comp_i   (comp),
    .rd_idx_i (pix_idx_i),
    .rgb_o    (pix_rgb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           redraw_o <= 1'b1;
    else if (data_wr)      redraw_o <= 1'b1;
    else if (redraw_ack_i) redraw_o <= 1'b0;
  end
endmodule

// File: rtl/pal_chk.sv
module pal_chk
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int NBYTES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_o,
  input logic             idx_wr,
  input logic             data_wr,
  input logic             comp_we,
  input logic             size_i,
  input logic [IDX_W-1:0] wdata_lo,
  input logic [IDX_W-1:0] idx_q,
  input phase_e           phase_q,
  input logic             redraw_o,
  input logic             redraw_ack_i
);
  localparam int LC_W = $clog2(NBYTES + 2);
  logic [LC_W-1:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        lo_cnt <= '0;
    else if (ready_o)                   lo_cnt <= '0;
    else if (lo_cnt != LC_W'(NBYTES+1)) lo_cnt <= lo_cnt + 1'b1;
  end

  AST_IDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> idx_q == $past(wdata_lo) && phase_q == PH_R); // R1
  AST_PHASE_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_we && phase_q == PH_R |=> phase_q == PH_G && $stable(idx_q)); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comp_we && !idx_wr |=> $stable(idx_q) && $stable(phase_q)); // R2
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_we && phase_q == PH_B |=> idx_q == $past(idx_q) + 1'b1 && phase_q == PH_R); // R3
  AST_WORD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && size_i |=> !ready_o); // R4
  AST_STALL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> lo_cnt < LC_W'(NBYTES)); // R4
  AST_REDRAW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> redraw_o); // R6
  AST_REDRAW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redraw_ack_i && !data_wr |=> !redraw_o); // R6
endmodule

bind seq_palette pal_chk #(.IDX_W(IDX_W), .NBYTES(BUS_W / COMP_W)) i_pal_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .idx_wr       (idx_wr),
  .data_wr      (data_wr),
  .comp_we      (comp_we),
  .size_i       (size_i),
  .wdata_lo     (wdata_i[IDX_W-1:0]),
  .idx_q        (idx_q),
  .phase_q      (phase_q),
  .redraw_o     (redraw_o),
  .redraw_ack_i (redraw_ack_i)
);

// File: tb/test_seq_palette.sv
`timescale 1ns/1ps
module test_seq_palette;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, size_i = 1'b0, redraw_ack_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ready_o, redraw_o;
  logic [7:0]  pix_idx_i = '0;
  logic [23:0] pix_rgb_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seq_palette i_seq_palette (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .rdata_o, .ready_o, .pix_idx_i, .pix_rgb_o, .redraw_o, .redraw_ack_i
  );

  localparam logic [1:0] K_IDX = 2'd0, K_BYTE = 2'd1, K_WORD = 2'd2, K_CHK = 2'd3;
  localparam int NV = 24;
  // {kind, write data, lookup index, expected rgb}
  localparam logic [65:0] VEC [NV] = '{
    {K_IDX,  32'h10, 8'h00, 24'h0},
    {K_BYTE, 32'h11, 8'h00, 24'h0},
    {K_BYTE, 32'h22, 8'h00, 24'h0},
    {K_BYTE, 32'h33, 8'h00, 24'h0},
    {K_CHK,  32'h0,  8'h10, 24'h112233},   // R2
    {K_WORD, 32'hAABBCCDD, 8'h00, 24'h0},
    {K_CHK,  32'h0,  8'h11, 24'hAABBCC},   // R4 msb first
    {K_BYTE, 32'h44, 8'h00, 24'h0},
    {K_BYTE, 32'h55, 8'h00, 24'h0},
    {K_CHK,  32'h0,  8'h12, 24'hDD4455},   // R3 carry into next entry
    {K_IDX,  32'h20, 8'h00, 24'h0},
    {K_BYTE, 32'h01, 8'h00, 24'h0},
    {K_IDX,  32'h20, 8'h00, 24'h0},
    {K_BYTE, 32'h02, 8'h00, 24'h0},
    {K_BYTE, 32'h03, 8'h00, 24'h0},
    {K_BYTE, 32'h04, 8'h00, 24'h0},
    {K_CHK,  32'h0,  8'h20, 24'h020304},   // R1 phase restart
    {K_IDX,  32'hFF, 8'h00, 24'h0},
    {K_WORD, 32'h0A0B0C0D, 8'h00, 24'h0},
    {K_BYTE, 32'h0E, 8'h00, 24'h0},
    {K_BYTE, 32'h0F, 8'h00, 24'h0},
    {K_CHK,  32'h0,  8'hFF, 24'h0A0B0C},   // R4
    {K_CHK,  32'h0,  8'h00, 24'h0D0E0F},   // R3 wrap
    {K_CHK,  32'h0,  8'h13, 24'h000000}    // R8 untouched entry
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic sz, input logic [31:0] d);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; size_i = sz; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic lookup(input string tag, input logic [7:0] ix, input logic [23:0] exp);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    pix_idx_i = ix;
    #0.5;
    check(tag, {8'h0, pix_rgb_o}, {8'h0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7 reset state
    lookup("R7 entry 00 cleared", 8'h00, 24'h0);
    lookup("R7 entry 7F cleared", 8'h7F, 24'h0);
    check("R7 redraw set", {31'h0, redraw_o}, 32'h1);
    check("R4 ready idle", {31'h0, ready_o}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      k = VEC[i][65:64];
      case (k)
        K_IDX:  bus_wr(5'h0, 1'b0, VEC[i][63:32]);
        K_BYTE: bus_wr(5'h4, 1'b0, VEC[i][63:32]);
        K_WORD: bus_wr(5'h4, 1'b1, VEC[i][63:32]);
        default: lookup($sformatf("R8 table row %0d", i), VEC[i][31:24], VEC[i][23:0]);
      endcase
    end

    // R4 ready timing of a word write
    bus_wr(5'h0, 1'b0, 32'h50);
    bus_wr(5'h4, 1'b1, 32'h01020304);
    check("R4 ready low c1", {31'h0, ready_o}, 32'h0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R4 ready low", {31'h0, ready_o}, 32'h0);
    end
    @(negedge clk);
    check("R4 ready back", {31'h0, ready_o}, 32'h1);
    lookup("R4 word entry 50", 8'h50, 24'h010203);

    // R5 reads return zero
    for (int a = 0; a < 2; a++) begin
      @(negedge clk);
      req_i = 1'b1; we_i = 1'b0; addr_i = (a == 0) ? 5'h0 : 5'h4;
      #0.5;
      check("R5 read zero", rdata_o, 32'h0);
      @(negedge clk);
      req_i = 1'b0;
    end

    // R6 redraw handshake
    @(negedge clk); redraw_ack_i = 1'b1;
    @(negedge clk); redraw_ack_i = 1'b0;
    check("R6 ack clears", {31'h0, redraw_o}, 32'h0);
    bus_wr(5'h0, 1'b0, 32'h60);
    check("R6 index write no redraw", {31'h0, redraw_o}, 32'h0);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 5'h4; size_i = 1'b0; wdata_i = 32'h9; redraw_ack_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; redraw_ack_i = 1'b0;
    check("R6 write beats ack", {31'h0, redraw_o}, 32'h1);

    // R9 other offsets ignored
    bus_wr(5'h0, 1'b0, 32'h30);
    bus_wr(5'h8, 1'b1, 32'h99999999);
    check("R9 ready stays high", {31'h0, ready_o}, 32'h1);
    bus_wr(5'h10, 1'b0, 32'h77);
    bus_wr(5'h4, 1'b0, 32'hA1);
    bus_wr(5'h4, 1'b0, 32'hA2);
    bus_wr(5'h4, 1'b0, 32'hA3);
    lookup("R9 sequence intact", 8'h30, 24'hA1A2A3);
    lookup("R9 no stray entry", 8'h99, 24'h0);

    // R7 reset mid-entry
    bus_wr(5'h0, 1'b0, 32'h40);
    bus_wr(5'h4, 1'b0, 32'h77);
    redraw_ack_i = 1'b1; @(negedge clk); redraw_ack_i = 1'b0;
    do_reset();
    check("R7 redraw after reset", {31'h0, redraw_o}, 32'h1);
    lookup("R7 entry 10 cleared", 8'h10, 24'h0);
    lookup("R7 entry 40 cleared", 8'h40, 24'h0);
    bus_wr(5'h4, 1'b0, 32'h61);
    bus_wr(5'h4, 1'b0, 32'h62);
    bus_wr(5'h4, 1'b0, 32'h63);
    lookup("R7 index 0 phase red", 8'h00, 24'h616263);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule